// File: doc/BRIEF.md
# Type-C Plug Orientation Detector and SuperSpeed Lane Steering

This block watches the two digitised Configuration Channel comparator levels of a reversible connector and works out whether a plug is present and which way round it sits. Each level is first synchronised. It then has to hold the same value for a programmable number of clock cycles before a four-state machine acts on it. That machine has a detached state, a pending (debounce) state and two attached states, one per orientation.

The machine drives a steering stage. Two SuperSpeed transmit lanes and two receive lanes exist, one of each per orientation. The steering stage connects the single link-side transmit stream and the single link-side receive stream to the lane pair the orientation selects. Both streams use valid/ready handshakes, and back-pressure follows the selected lane. When no plug is seen, every lane output is forced to zero and the link sees no valid data and no ready.

The legacy USB 2.0 differential pair is carried straight from input to output, whatever the orientation. The rule set allows a new orientation only after the block has passed through the detached state. An invalid pattern, with both channels high, freezes the state and raises an error flag.

Top module: `typec_orient_mux`

## Requirements
- R1: After reset, `attached`, `flipped` and `cc_err` are 0.
- R2: With `cc1_in`=1 and `cc2_in`=0 held from a detached start, `attached` goes to 1 and `flipped` stays 0 on the (`dbnc_len`+4)-th rising edge after the change, and not earlier. The transmit stream then drives lane 1 (`ss_tx1_*`) and the receive stream comes from lane 1 (`ss_rx1_*`).
- R3: With `cc1_in`=0 and `cc2_in`=1 accepted, `attached`=1 and `flipped`=1. The transmit stream drives lane 2 and the receive stream comes from lane 2.
- R4: A CC pattern that holds for fewer than `dbnc_len` cycles before changing again does not change `attached` or `flipped`.
- R5: While `attached`=0, all lane data and valid outputs, `ss_rx1_ready`, `ss_rx2_ready`, `tx_ready`, `rx_valid` and `rx_data` are 0.
- R6: A stable pattern with both CC inputs high leaves the state unchanged and sets `cc_err` to 1 one edge after the pattern is accepted. `cc_err` returns to 0 once another pattern is accepted.
- R7: The orientation never goes directly from normal to flipped. A stable swap of the pattern while attached first drives `attached` to 0 on edge `dbnc_len`+4 and `dbnc_len`+5, then sets `flipped` on edge `dbnc_len`+6.
- R8: Both CC inputs low, held stable for `dbnc_len` cycles while attached, clears `attached` on the (`dbnc_len`+4)-th edge.
- R9: On the selected lane, `tx_ready` follows that lane's ready input, and `rx_ready` reaches only that lane's ready output. The unselected lane sees valid 0, data 0 and ready 0.
- R10: `dp_out` equals `dp_in` and `dn_out` equals `dn_in` at all times, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbnc_len | input | CNT_W | Cycles a CC pattern must stay stable |
| cc1_in | input | 1 | Channel 1 comparator level |
| cc2_in | input | 1 | Channel 2 comparator level |
| attached | output | 1 | Plug accepted |
| flipped | output | 1 | 1 = reversed orientation (lane 2) |
| cc_err | output | 1 | Both channels high accepted |
| tx_data | input | LANE_W | Link transmit data |
| tx_valid | input | 1 | Link transmit valid |
| tx_ready | output | 1 | Selected transmit lane ready |
| ss_tx1_data | output | LANE_W | Lane 1 transmit data |
| ss_tx1_valid | output | 1 | Lane 1 transmit valid |
| ss_tx1_ready | input | 1 | Lane 1 transmit ready |
| ss_tx2_data | output | LANE_W | Lane 2 transmit data |
| ss_tx2_valid | output | 1 | Lane 2 transmit valid |
| ss_tx2_ready | input | 1 | Lane 2 transmit ready |
| ss_rx1_data | input | LANE_W | Lane 1 receive data |
| ss_rx1_valid | input | 1 | Lane 1 receive valid |
| ss_rx1_ready | output | 1 | Lane 1 receive ready |
| ss_rx2_data | input | LANE_W | Lane 2 receive data |
| ss_rx2_valid | input | 1 | Lane 2 receive valid |
| ss_rx2_ready | output | 1 | Lane 2 receive ready |
| rx_data | output | LANE_W | Link receive data |
| rx_valid | output | 1 | Link receive valid |
| rx_ready | input | 1 | Link receive ready |
| dp_in | input | 1 | Legacy pair positive in |
| dn_in | input | 1 | Legacy pair negative in |
| dp_out | output | 1 | Legacy pair positive out |
| dn_out | output | 1 | Legacy pair negative out |

## Verification
The hardest situation to reach is a swap of orientation while attached. The machine must be seen leaving through the detached state and then re-entering through the pending state, both while the swapped pattern is already stable. The stimulus attaches in normal orientation and then changes both CC inputs in one cycle. It samples `attached` and `flipped` on each edge from `dbnc_len`+3 to `dbnc_len`+6. A bounce shorter than the debounce window and an accepted both-high pattern are driven in the same way, with the checks landing on the exact edge where acceptance would occur.

// File: rtl/typec_orient_pkg.sv
package typec_orient_pkg;
  typedef enum logic [1:0] {
    ST_DETACHED = 2'd0,
    ST_PENDING  = 2'd1,
    ST_NORMAL   = 2'd2,
    ST_FLIPPED  = 2'd3
  } orient_state_t;

  // CC pattern encoding: bit 1 = channel 1, bit 0 = channel 2
  localparam logic [1:0] CC_NONE    = 2'b00;
  localparam logic [1:0] CC_REVERSE = 2'b01;
  localparam logic [1:0] CC_FORWARD = 2'b10;
  localparam logic [1:0] CC_BOTH    = 2'b11;
endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cc_debounce.sv
module cc_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len,
  input  logic [1:0]       cc_s,
  output logic [1:0]       cc_q,
  output logic             stable
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= '0;
      cnt  <= '0;
    end else if (cc_s != cc_q) begin
      cc_q <= cc_s;
      cnt  <= '0;
    end else if (cnt < len) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign stable = (cnt >= len);

  // a newly stable pattern must be the one held during the window
  AST_STABLE_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> (cc_q == $past(cc_q))); // R4
endmodule

// File: rtl/orient_fsm.sv
module orient_fsm
  import typec_orient_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cc_q,
  input  logic       stable,
  output logic       attached,
  output logic       flipped,
  output logic       cc_err
);
  orient_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_DETACHED:
        if (cc_q == CC_FORWARD || cc_q == CC_REVERSE) state_nx = ST_PENDING;
      ST_PENDING:
        if (stable) begin
          if (cc_q == CC_FORWARD)      state_nx = ST_NORMAL;
          else if (cc_q == CC_REVERSE) state_nx = ST_FLIPPED;
          else if (cc_q == CC_NONE)    state_nx = ST_DETACHED;
        end
      ST_NORMAL:
        if (stable && (cc_q == CC_NONE || cc_q == CC_REVERSE)) state_nx = ST_DETACHED;
      ST_FLIPPED:
        if (stable && (cc_q == CC_NONE || cc_q == CC_FORWARD)) state_nx = ST_DETACHED;
      default: state_nx = ST_DETACHED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_DETACHED;
      cc_err <= 1'b0;
    end else begin
      state <= state_nx;
      if (stable) cc_err <= (cc_q == CC_BOTH);
    end
  end

  assign attached = (state == ST_NORMAL) || (state == ST_FLIPPED);
  assign flipped  = (state == ST_FLIPPED);

  AST_NO_DIRECT_SWAP_N: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL) |=> (state != ST_FLIPPED)); // R7
  AST_NO_DIRECT_SWAP_F: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLIPPED) |=> (state != ST_NORMAL)); // R7
  AST_ATTACH_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attached) |-> $past(stable)); // R2
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && cc_q == CC_BOTH) |=> (state == $past(state))); // R6
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int LANE_W = 16,
  parameter int NLANE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attached,
  input  logic              flipped,
  input  logic [LANE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [LANE_W-1:0] ln_tx_data  [NLANE],
  output logic              ln_tx_valid [NLANE],
  input  logic              ln_tx_ready [NLANE],
  input  logic [LANE_W-1:0] ln_rx_data  [NLANE],
  input  logic              ln_rx_valid [NLANE],
  output logic              ln_rx_ready [NLANE],
  output logic [LANE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  localparam int IDX_W = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [NLANE-1:0] sel;
  logic [IDX_W-1:0] idx;

  assign idx = IDX_W'(flipped);

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign sel[g]         = attached && (idx == IDX_W'(g));
      assign ln_tx_data[g]  = sel[g] ? tx_data : '0;
      assign ln_tx_valid[g] = sel[g] && tx_valid;
      assign ln_rx_ready[g] = sel[g] && rx_ready;
    end
  endgenerate

  always_comb begin
    tx_ready = 1'b0;
    rx_valid = 1'b0;
    rx_data  = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (sel[i]) begin
        tx_ready = ln_tx_ready[i];
        rx_valid = ln_rx_valid[i];
        rx_data  = ln_rx_data[i];
      end
    end
  end

  AST_IDLE_WHEN_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
    !attached |-> (!tx_ready && !rx_valid && rx_data == '0)); // R5
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R9
endmodule

// File: rtl/typec_orient_mux.sv
module typec_orient_mux #(
  parameter int LANE_W    = 16,
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  dbnc_len,
  input  logic              cc1_in,
  input  logic              cc2_in,
  output logic              attached,
  output logic              flipped,
  output logic              cc_err,
  input  logic [LANE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [LANE_W-1:0] ss_tx1_data,
  output logic              ss_tx1_valid,
  input  logic              ss_tx1_ready,
  output logic [LANE_W-1:0] ss_tx2_data,
  output logic              ss_tx2_valid,
  input  logic              ss_tx2_ready,
  input  logic [LANE_W-1:0] ss_rx1_data,
  input  logic              ss_rx1_valid,
  output logic              ss_rx1_ready,
  input  logic [LANE_W-1:0] ss_rx2_data,
  input  logic              ss_rx2_valid,
  output logic              ss_rx2_ready,
  output logic [LANE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              dp_in,
  input  logic              dn_in,
  output logic              dp_out,
  output logic              dn_out
);
  localparam int NLANE = 2;

  logic [1:0] cc_s, cc_q;
  logic       stable;

  logic [LANE_W-1:0] ln_tx_data  [NLANE];
  logic              ln_tx_valid [NLANE];
  logic              ln_tx_ready [NLANE];
  logic [LANE_W-1:0] ln_rx_data  [NLANE];
  logic              ln_rx_valid [NLANE];
  logic              ln_rx_ready [NLANE];

  cc_sync #(.STAGES(SYNC_STGS), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cc1_in, cc2_in}), .d_out(cc_s)
  );

  cc_debounce #(.CNT_W(CNT_W)) u_dbnc (
    .clk(clk), .rst_n(rst_n), .len(dbnc_len), .cc_s(cc_s),
    .cc_q(cc_q), .stable(stable)
  );

  orient_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cc_q(cc_q), .stable(stable),
    .attached(attached), .flipped(flipped), .cc_err(cc_err)
  );

  assign ln_tx_ready[0] = ss_tx1_ready;
  assign ln_tx_ready[1] = ss_tx2_ready;
  assign ln_rx_data[0]  = ss_rx1_data;
  assign ln_rx_data[1]  = ss_rx2_data;
  assign ln_rx_valid[0] = ss_rx1_valid;
  assign ln_rx_valid[1] = ss_rx2_valid;
  assign ss_tx1_data    = ln_tx_data[0];
  assign ss_tx2_data    = ln_tx_data[1];
  assign ss_tx1_valid   = ln_tx_valid[0];
  assign ss_tx2_valid   = ln_tx_valid[1];
  assign ss_rx1_ready   = ln_rx_ready[0];
  assign ss_rx2_ready   = ln_rx_ready[1];

  lane_steer #(.LANE_W(LANE_W), .NLANE(NLANE)) u_steer (
    .clk(clk), .rst_n(rst_n), .attached(attached), .flipped(flipped),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ln_tx_data(ln_tx_data), .ln_tx_valid(ln_tx_valid), .ln_tx_ready(ln_tx_ready),
    .ln_rx_data(ln_rx_data), .ln_rx_valid(ln_rx_valid), .ln_rx_ready(ln_rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // legacy pair is wired through, never swapped
  assign dp_out = dp_in;
  assign dn_out = dn_in;

  AST_LEGACY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_out == dp_in) && (dn_out == dn_in)); // R10
endmodule

// File: tb/typec_orient_mux_test.sv
module typec_orient_mux_test;
  localparam int LANE_W = 16;
  localparam int CNT_W  = 16;
  localparam int LEN    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] dbnc_len = CNT_W'(LEN);
  logic cc1_in = 0, cc2_in = 0;
  logic attached, flipped, cc_err;
  logic [LANE_W-1:0] tx_data = '0;
  logic tx_valid = 0, tx_ready;
  logic [LANE_W-1:0] ss_tx1_data, ss_tx2_data;
  logic ss_tx1_valid, ss_tx2_valid;
  logic ss_tx1_ready = 0, ss_tx2_ready = 0;
  logic [LANE_W-1:0] ss_rx1_data = '0, ss_rx2_data = '0;
  logic ss_rx1_valid = 0, ss_rx2_valid = 0;
  logic ss_rx1_ready, ss_rx2_ready;
  logic [LANE_W-1:0] rx_data;
  logic rx_valid, rx_ready = 0;
  logic dp_in = 0, dn_in = 1, dp_out, dn_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  typec_orient_mux #(.LANE_W(LANE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .dbnc_len(dbnc_len), .cc1_in(cc1_in), .cc2_in(cc2_in),
    .attached(attached), .flipped(flipped), .cc_err(cc_err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ss_tx1_data(ss_tx1_data), .ss_tx1_valid(ss_tx1_valid), .ss_tx1_ready(ss_tx1_ready),
    .ss_tx2_data(ss_tx2_data), .ss_tx2_valid(ss_tx2_valid), .ss_tx2_ready(ss_tx2_ready),
    .ss_rx1_data(ss_rx1_data), .ss_rx1_valid(ss_rx1_valid), .ss_rx1_ready(ss_rx1_ready),
    .ss_rx2_data(ss_rx2_data), .ss_rx2_valid(ss_rx2_valid), .ss_rx2_ready(ss_rx2_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .dp_in(dp_in), .dn_in(dn_in), .dp_out(dp_out), .dn_out(dn_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // set CC at a falling edge, then sample at the falling edge after n rising edges
  task automatic drive_cc(input logic a, input logic b);
    cc1_in = a; cc2_in = b;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 attached", {31'b0, attached}, 0);
    chk("R1 flipped", {31'b0, flipped}, 0);
    chk("R1 cc_err", {31'b0, cc_err}, 0);
    tx_valid = 1; tx_data = 16'hA5A5; ss_tx1_ready = 1; ss_tx2_ready = 1;
    ss_rx1_valid = 1; ss_rx2_valid = 1; ss_rx1_data = 16'h1111; ss_rx2_data = 16'h2222;
    rx_ready = 1;
    #1;
    chk("R5 idle lanes", {ss_tx1_valid, ss_tx2_valid, tx_ready, rx_valid,
                          ss_rx1_ready, ss_rx2_ready}, 0);
    chk("R5 idle data", {ss_tx1_data, ss_tx2_data}, 0);
    chk("R5 rx_data", {16'b0, rx_data}, 0);
  endtask

  task automatic t_bounce();
    drive_cc(1, 0); edges(LEN - 3);
    drive_cc(0, 0); edges(LEN + 6);
    chk("R4 bounce attached", {31'b0, attached}, 0);
    drive_cc(0, 1); edges(2);
    drive_cc(1, 0); edges(2);
    drive_cc(0, 0); edges(LEN + 6);
    chk("R4 bounce flip", {30'b0, attached, flipped}, 0);
  endtask

  task automatic t_attach_normal();
    drive_cc(1, 0); edges(LEN + 3);
    chk("R2 not yet attached", {31'b0, attached}, 0);
    edges(1);
    chk("R2 attached normal", {30'b0, attached, flipped}, 32'h2);
    ss_tx1_ready = 0; ss_tx2_ready = 1; #1;
    chk("R2 tx to lane1", {ss_tx1_valid, ss_tx1_data}, {1'b1, 16'hA5A5});
    chk("R9 lane2 idle", {ss_tx2_valid, ss_tx2_data, ss_rx2_ready}, 0);
    chk("R9 backpressure lane1", {31'b0, tx_ready}, 0);
    ss_tx1_ready = 1; #1;
    chk("R9 ready lane1", {31'b0, tx_ready}, 1);
    chk("R2 rx from lane1", {rx_valid, rx_data, ss_rx1_ready}, {15'b0, 1'b1, 16'h1111, 1'b1});
    chk("R10 legacy pass", {dp_out, dn_out}, {dp_in, dn_in});
  endtask

  task automatic t_invalid();
    drive_cc(1, 1); edges(LEN + 3);
    chk("R6 err not yet", {31'b0, cc_err}, 0);
    edges(1);
    chk("R6 err set", {31'b0, cc_err}, 1);
    chk("R6 state held", {30'b0, attached, flipped}, 32'h2);
    drive_cc(1, 0); edges(LEN + 4);
    chk("R6 err cleared", {29'b0, cc_err, attached, flipped}, 32'h2);
  endtask

  task automatic t_swap();
    drive_cc(0, 1); edges(LEN + 3);
    chk("R7 still normal", {30'b0, attached, flipped}, 32'h2);
    edges(1);
    chk("R7 detached first", {30'b0, attached, flipped}, 0);
    edges(1);
    chk("R7 pending", {30'b0, attached, flipped}, 0);
    edges(1);
    chk("R7 flipped", {30'b0, attached, flipped}, 32'h3);
    ss_tx1_ready = 1; ss_tx2_ready = 0; #1;
    chk("R3 tx to lane2", {ss_tx2_valid, ss_tx2_data}, {1'b1, 16'hA5A5});
    chk("R3 lane1 idle", {ss_tx1_valid, ss_tx1_data, ss_rx1_ready}, 0);
    chk("R9 backpressure lane2", {31'b0, tx_ready}, 0);
    chk("R3 rx from lane2", {rx_valid, rx_data, ss_rx2_ready}, {15'b0, 1'b1, 16'h2222, 1'b1});
  endtask

  task automatic t_detach();
    drive_cc(0, 0); edges(LEN + 3);
    chk("R8 still attached", {31'b0, attached}, 1);
    edges(1);
    chk("R8 detached", {30'b0, attached, flipped}, 0);
    dp_in = 1; dn_in = 0; #1;
    chk("R10 legacy detached", {dp_out, dn_out}, 32'h2);
    chk("R5 idle after detach", {ss_tx1_valid, ss_tx2_valid, tx_ready, rx_valid}, 0);
  endtask

  task automatic t_attach_flipped();
    drive_cc(0, 1); edges(LEN + 4);
    chk("R3 direct flipped", {30'b0, attached, flipped}, 32'h3);
    dp_in = 0; dn_in = 1; #1;
    chk("R10 legacy flipped", {dp_out, dn_out}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    edges(1);
    t_reset();
    t_bounce();
    t_attach_normal();
    t_invalid();
    t_swap();
    t_detach();
    t_attach_flipped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule